// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block is the digital feedback divider of a frequency synthesizer loop. It runs on the fast input clock and produces a single-cycle output pulse once per divided period. The average division ratio is N = P·M + A + F/32. The prescaler modulus P is fixed by a parameter: 32 for the wide variant and 16 for the narrow variant.

Each divided period is built from M prescaler cycles. The first A of these cycles are stretched to P+1 input cycles, and the rest last P input cycles. A 5-bit accumulator adds the numerator F once per period. When the accumulator wraps, it stretches one more prescaler cycle of the next period. Because the accumulator works modulo 32, an even numerator behaves as a reduced fraction with denominator 16, 8, 4 or 2.

Software-side logic presents a new (M, A, F) triple with a one-cycle load strobe. The triple is held aside and takes over only at the next period boundary. A counter-clear input restarts the counter chain and the accumulator, so the divider can be realigned with the reference path.

Top module: `fracn_swallow_div`

## Requirements
- R1: While `rst` is high, `div_pulse` stays low. Reset selects the default configuration M=32, A=0, F=0. The first pulse appears in the first cycle after the first clock edge with `rst` low, and the next period then lasts 32·P input cycles.
- R2: With F=0, every period lasts exactly P·M + A input cycles. This holds over the whole legal range, from M=3 up to M=511 with A up to its maximum of P−1.
- R3: With a nonzero F, period k after a clear lasts P·M + A + c_k cycles, where c_k = floor(k·F/32) − floor((k−1)·F/32). Any 32 consecutive periods therefore total 32·(P·M+A) + F. This includes A = M−1, where the wrap makes the swallow count equal M.
- R4: An even numerator follows the reduced fraction. F=8 lengthens only every fourth period, and F=16 lengthens every second period.
- R5: While `cnt_clr` is high, `div_pulse` stays low. Clearing zeroes the accumulator and restarts the counter chain but keeps the configuration. The first pulse follows one cycle after release, as in R1.
- R6: A triple loaded during a period does not change that period. It governs the next period and the ones after it.
- R7: A load with M < 3 or A ≥ M is ignored, and the period length stays unchanged.
- R8: With P=16, `a_in` is 4 bits wide and the periods follow R3 with P=16. For example, M=10, A=3, F=2 gives 32 periods totalling 5218 cycles.
- R9: `div_pulse` is exactly one input cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; restores the default configuration |
| cnt_clr | input | 1 | Synchronous counter clear; keeps the configuration |
| cfg_load | input | 1 | One-cycle strobe that captures `m_in`, `a_in`, `f_in` |
| m_in | input | 9 | Main counter value, 3 to 511 |
| a_in | input | PRESC_LOG2 | Swallow count, must be below M |
| f_in | input | 5 | Fractional numerator over 32 |
| div_pulse | output | 1 | One-cycle pulse per divided period |

## Verification
Several properties are checked on every cycle:
- the configuration that will be committed is always legal;
- the active configuration changes only at a period boundary;
- the remaining swallow count never reaches the remaining main count;
- the pulse is one cycle wide and absent during a clear;
- the accumulator moves down exactly when it emits a carry.

Other properties only the directed scenarios can show, by counting input cycles between pulses:
- the exact period lengths;
- the 32-period totals and the reduced-fraction patterns;
- the one-period delay before a new triple applies;
- that a rejected load leaves the period untouched.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;

    localparam int M_W     = 9;   // main counter width
    localparam int A_MAX_W = 5;   // widest swallow field (P = 32)
    localparam int F_W     = 5;   // fractional numerator, modulo 32
    localparam int M_MIN   = 3;   // smallest legal main count

    typedef struct packed {
        logic [M_W-1:0]     m;
        logic [A_MAX_W-1:0] a;
        logic [F_W-1:0]     f;
    } div_cfg_t;

    // A triple is usable when M is in range and the swallow count fits inside M.
    function automatic logic cfg_legal(logic [M_W-1:0] m, logic [A_MAX_W-1:0] a);
        return (m >= M_W'(M_MIN)) && ({{(M_W-A_MAX_W){1'b0}}, a} < m);
    endfunction

endpackage

// File: rtl/fracn_cfg_stage.sv
`timescale 1ns/1ps
module fracn_cfg_stage
    import fracn_pkg::*;
#(
    parameter div_cfg_t RESET_CFG = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     commit,
    input  div_cfg_t cfg_in,
    output div_cfg_t next_cfg
);

    div_cfg_t stg_q;
    div_cfg_t act_q;
    logic     pend_q;
    logic     in_ok;

    assign in_ok = cfg_legal(cfg_in.m, cfg_in.a);

    // The triple the next boundary will use: a waiting one wins over the active one.
    assign next_cfg = pend_q ? stg_q : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q  <= RESET_CFG;
            act_q  <= RESET_CFG;
            pend_q <= 1'b0;
        end else begin
            if (commit) begin
                act_q <= next_cfg;
            end
            if (load && in_ok) begin
                stg_q  <= cfg_in;
                pend_q <= 1'b1;
            end else if (commit) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_NEXT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cfg_legal(next_cfg.m, next_cfg.a)); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act_q)); // R6

endmodule

// File: rtl/fracn_frac_acc.sv
`timescale 1ns/1ps
module fracn_frac_acc
    import fracn_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           step,
    input  logic [F_W-1:0] frac,
    output logic           carry
);

    logic [F_W-1:0] acc_q;
    logic [F_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign carry = sum[F_W];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[F_W-1:0];
        end
    end

    AST_ACC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && carry) |=> (acc_q < $past(acc_q))); // R3

    AST_ACC_RISE: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && !carry) |=> (acc_q >= $past(acc_q))); // R3

endmodule

// File: rtl/fracn_prescaler.sv
`timescale 1ns/1ps
module fracn_prescaler #(
    parameter int PRESC_LOG2 = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_plus1,
    output logic wrap
);

    localparam int                PRE_W    = PRESC_LOG2 + 1;
    localparam logic [PRE_W-1:0]  LOAD_P1  = PRE_W'(1 << PRESC_LOG2);        // P+1 cycles
    localparam logic [PRE_W-1:0]  LOAD_P   = PRE_W'((1 << PRESC_LOG2) - 1);  // P cycles

    logic [PRE_W-1:0] pre_q;

    assign wrap = (pre_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (wrap) begin
            pre_q <= sel_plus1 ? LOAD_P1 : LOAD_P;
        end else begin
            pre_q <= pre_q - PRE_W'(1);
        end
    end

    AST_PRE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LOAD_P1); // R2

endmodule

// File: rtl/fracn_mod_ctl.sv
`timescale 1ns/1ps
module fracn_mod_ctl
    import fracn_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wrap,
    input  logic [M_W-1:0]     m_next,
    input  logic [A_MAX_W:0]   swl_start,
    output logic               sel_plus1,
    output logic               boundary,
    output logic               div_pulse
);

    localparam int SWL_W = A_MAX_W + 1;

    logic [M_W-1:0]   main_q;
    logic [SWL_W-1:0] swl_q;
    logic             pulse_q;

    // The last prescaler cycle of a period ends when the main count reaches one.
    assign boundary  = wrap && (main_q <= M_W'(1));
    assign sel_plus1 = boundary ? (swl_start != '0) : (swl_q != '0);
    assign div_pulse = pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q  <= M_W'(1);
            swl_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= boundary;
            if (boundary) begin
                main_q <= m_next;
                swl_q  <= (swl_start != '0) ? swl_start - SWL_W'(1) : '0;
            end else if (wrap) begin
                main_q <= main_q - M_W'(1);
                swl_q  <= (swl_q != '0) ? swl_q - SWL_W'(1) : '0;
            end
        end
    end

    AST_SWL_BELOW_MAIN: assert property (@(posedge clk) disable iff (rst)
        (swl_q == '0) || (M_W'(swl_q) < main_q)); // R2

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R9

endmodule

// File: rtl/fracn_swallow_div.sv
`timescale 1ns/1ps
module fracn_swallow_div
    import fracn_pkg::*;
#(
    parameter int PRESC_LOG2 = 5,
    parameter int DEF_M      = 32,
    parameter int DEF_A      = 0,
    parameter int DEF_F      = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cnt_clr,
    input  logic                  cfg_load,
    input  logic [M_W-1:0]        m_in,
    input  logic [PRESC_LOG2-1:0] a_in,
    input  logic [F_W-1:0]        f_in,
    output logic                  div_pulse
);

    localparam int       SWL_W     = A_MAX_W + 1;
    localparam div_cfg_t RESET_CFG = '{m: M_W'(DEF_M), a: A_MAX_W'(DEF_A), f: F_W'(DEF_F)};

    logic [A_MAX_W-1:0] a_ext;
    div_cfg_t           cfg_in;
    div_cfg_t           next_cfg;
    logic               cnt_rst;
    logic               boundary;
    logic               carry;
    logic               sel_plus1;
    logic               wrap;
    logic [SWL_W-1:0]   swl_start;

    if (PRESC_LOG2 < A_MAX_W) begin : g_narrow_a
        assign a_ext = {{(A_MAX_W-PRESC_LOG2){1'b0}}, a_in};
    end else begin : g_wide_a
        assign a_ext = a_in[A_MAX_W-1:0];
    end

    assign cfg_in    = '{m: m_in, a: a_ext, f: f_in};
    assign cnt_rst   = rst || cnt_clr;
    // A fractional carry simply adds one more stretched prescaler cycle.
    assign swl_start = {1'b0, next_cfg.a} + SWL_W'(carry);

    fracn_cfg_stage #(
        .RESET_CFG (RESET_CFG)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .commit   (boundary),
        .cfg_in   (cfg_in),
        .next_cfg (next_cfg)
    );

    fracn_frac_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .step  (boundary),
        .frac  (next_cfg.f),
        .carry (carry)
    );

    fracn_prescaler #(
        .PRESC_LOG2 (PRESC_LOG2)
    ) u_pre (
        .clk       (clk),
        .rst       (cnt_rst),
        .sel_plus1 (sel_plus1),
        .wrap      (wrap)
    );

    fracn_mod_ctl u_ctl (
        .clk       (clk),
        .rst       (cnt_rst),
        .wrap      (wrap),
        .m_next    (next_cfg.m),
        .swl_start (swl_start),
        .sel_plus1 (sel_plus1),
        .boundary  (boundary),
        .div_pulse (div_pulse)
    );

    AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (rst)
        boundary |-> (M_W'(swl_start) <= next_cfg.m)); // R2

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> !div_pulse); // R5

endmodule

// File: tb/fracn_swallow_div_tb.sv
`timescale 1ns/1ps
module fracn_swallow_div_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst   = 1'b1;
    logic       clr_w = 1'b0, ld_w = 1'b0;
    logic [8:0] m_w   = '0;
    logic [4:0] a_w   = '0, f_w = '0;
    logic       pulse_w;
    logic       clr_n = 1'b0, ld_n = 1'b0;
    logic [8:0] m_n   = '0;
    logic [3:0] a_n   = '0;
    logic [4:0] f_n   = '0;
    logic       pulse_n;

    int checks = 0;
    int errors = 0;

    fracn_swallow_div #(.PRESC_LOG2(5)) u_dut (
        .clk(clk), .rst(rst), .cnt_clr(clr_w), .cfg_load(ld_w),
        .m_in(m_w), .a_in(a_w), .f_in(f_w), .div_pulse(pulse_w));

    fracn_swallow_div #(.PRESC_LOG2(4)) u_dut16 (
        .clk(clk), .rst(rst), .cnt_clr(clr_n), .cfg_load(ld_n),
        .m_in(m_n), .a_in(a_n), .f_in(f_n), .div_pulse(pulse_n));

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int carry_k(input int k, input int f);
        return (k * f) / 32 - ((k - 1) * f) / 32;
    endfunction

    // Counts negedges from the current pulse to the next one.
    task automatic get_period(input bit narrow, output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
            ld_w = 1'b0;
            ld_n = 1'b0;
        end while (!(narrow ? pulse_n : pulse_w));
    endtask

    task automatic set_cfg(input bit narrow, input int m, input int a, input int f);
        if (narrow) begin
            m_n = 9'(m); a_n = 4'(a); f_n = 5'(f); ld_n = 1'b1;
        end else begin
            m_w = 9'(m); a_w = 5'(a); f_w = 5'(f); ld_w = 1'b1;
        end
    endtask

    task automatic do_clear(input bit narrow);
        int len;
        @(negedge clk);
        ld_w = 1'b0; ld_n = 1'b0;
        if (narrow) clr_n = 1'b1; else clr_w = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5", "pulse during clear", narrow ? pulse_n : pulse_w, 0);
        end
        clr_n = 1'b0; clr_w = 1'b0;
        get_period(narrow, len);
        check("R5", "first pulse after clear", len, 1);
    endtask

    task automatic run_frac(input bit narrow, input int p, input int m, input int a,
                            input int f, input int n, input string req);
        int len;
        longint total = 0;
        for (int k = 1; k <= n; k++) begin
            get_period(narrow, len);
            check(req, $sformatf("period %0d", k), len, p * m + a + carry_k(k, f));
            total += len;
        end
        check(req, "period total", total, n * (p * m + a) + (n * f) / 32);
    endtask

    task automatic t_reset();
        int len;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", "pulse in reset", pulse_w | pulse_n, 0);
        end
        rst = 1'b0;
        get_period(1'b0, len);
        check("R1", "first pulse after reset", len, 1);
        get_period(1'b0, len);
        check("R1", "default period", len, 1024);
        check("R9", "pulse one cycle wide", (len > 1) ? 1 : 0, 1);
    endtask

    task automatic t_integer();
        int len;
        set_cfg(1'b0, 40, 5, 0);
        get_period(1'b0, len);
        check("R6", "period after load keeps old ratio", len, 1024);
        get_period(1'b0, len);
        check("R2", "M=40 A=5", len, 1285);
        set_cfg(1'b0, 3, 2, 0);
        get_period(1'b0, len);
        check("R6", "period after load keeps old ratio", len, 1285);
        get_period(1'b0, len);
        check("R2", "M=3 A=2", len, 98);
        set_cfg(1'b0, 511, 31, 0);
        get_period(1'b0, len);
        check("R6", "period after load keeps old ratio", len, 98);
        get_period(1'b0, len);
        check("R2", "M=511 A=31", len, 16383);
    endtask

    task automatic t_reject();
        int len;
        set_cfg(1'b0, 10, 3, 0);
        get_period(1'b0, len);
        get_period(1'b0, len);
        check("R2", "M=10 A=3", len, 323);
        set_cfg(1'b0, 10, 12, 0);
        get_period(1'b0, len);
        get_period(1'b0, len);
        check("R7", "A>=M load ignored", len, 323);
        set_cfg(1'b0, 2, 0, 0);
        get_period(1'b0, len);
        get_period(1'b0, len);
        check("R7", "M=2 load ignored", len, 323);
    endtask

    task automatic t_fraction();
        set_cfg(1'b0, 37, 1, 3);
        do_clear(1'b0);
        run_frac(1'b0, 32, 37, 1, 3, 32, "R3");
        set_cfg(1'b0, 3, 2, 31);
        do_clear(1'b0);
        run_frac(1'b0, 32, 3, 2, 31, 4, "R3");
    endtask

    task automatic t_even();
        set_cfg(1'b0, 3, 0, 8);
        do_clear(1'b0);
        run_frac(1'b0, 32, 3, 0, 8, 8, "R4");
        set_cfg(1'b0, 3, 0, 16);
        do_clear(1'b0);
        run_frac(1'b0, 32, 3, 0, 16, 4, "R4");
    endtask

    task automatic t_narrow();
        set_cfg(1'b1, 10, 3, 2);
        do_clear(1'b1);
        run_frac(1'b1, 16, 10, 3, 2, 32, "R8");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_integer();
        t_reject();
        t_fraction();
        t_even();
        t_narrow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule